// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers a parameterized number of level-sensitive interrupt lines (32 by default) into one combined interrupt output. Each line drives a pending bit that simply follows the line's level, as sampled every clock. A mask held in the block decides which pending bits count. The combined output is high whenever at least one unmasked line is pending.

Software reaches the block through a small word-addressed register port. The port uses a single-cycle valid strobe with a write flag, an address and write data. Two readable locations return the number of active (pending and unmasked) lines, or the active vector itself. Three write-only locations set mask bits, clear mask bits, or wipe both the mask and the pending state in one access. For debug, a free-running counter per line counts rising edges of that line.

Top module: `lvl_irq_hub`

## Requirements
- R1: Synchronous reset clears the pending vector, the enable mask, every per-line counter, `irq_out` and `bus_rdata`.
- R2: A read at offset 0x00 returns, on `bus_rdata` in the cycle after the request, the count of set bits in (pending AND enable), in the range 0 to NLINES.
- R3: A read at offset 0x04 returns, in the cycle after the request, the vector (pending AND enable) in bits [NLINES-1:0], never the unmasked pending vector.
- R4: Any write at offset 0x08 clears the whole enable mask and the whole pending vector at the next clock edge, for any data value.
- R5: A write at offset 0x0C clears each enable bit whose data bit is 1. A write at offset 0x10 sets each enable bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R6: Pending bit i takes the level of line i sampled at each clock edge, so it rises while the line is high and falls once it is low.
- R7: `irq_out` is registered and, after each clock edge, is 1 exactly when (pending AND enable) is nonzero as updated at that same edge.
- R8: When a line is high in the same cycle as a write at offset 0x08, the clear wins for that edge, and the pending bit returns at the following edge if the line is still high.
- R9: Reads of any other offset (including the write-only ones and misaligned addresses), and cycles without a read request, give `bus_rdata` = 0. Writes to offsets 0x00, 0x04 or unmapped offsets change nothing.
- R10: Per-line counter i (field [i*CNT_W +: CNT_W] of `dbg_counts`) increments on each clock where line i is sampled high after being sampled low. It wraps modulo 2^CNT_W, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NLINES | Level-sensitive interrupt inputs |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data, valid the cycle after a read |
| irq_out | output | 1 | Combined registered interrupt |
| dbg_counts | output | NLINES*CNT_W | Per-line rising-edge counters, line i at [i*CNT_W +: CNT_W] |

## Verification
The bench keeps NLINES at 32, so the count read reaches its upper bound of 32 with every line high and every line enabled. It shrinks CNT_W to 4 so that a line toggled about twenty times makes its counter wrap within a short run. The full 32-bit mask and vector paths stay at their real width. A behavioural reference model runs alongside the design. It covers a clear-all while lines are high, writes to read-only and unmapped offsets, and a long stretch of mixed random line levels and register accesses.

// File: rtl/lvl_irq_hub_pkg.sv
package lvl_irq_hub_pkg;
  localparam int unsigned OFF_ACTIVE_CNT = 'h00;
  localparam int unsigned OFF_ACTIVE_VEC = 'h04;
  localparam int unsigned OFF_WIPE       = 'h08;
  localparam int unsigned OFF_MASK_OFF   = 'h0C;
  localparam int unsigned OFF_MASK_ON    = 'h10;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_WIPE,
    WR_MASK_OFF,
    WR_MASK_ON
  } wr_op_e;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import lvl_irq_hub_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  output wr_op_e        op
);
  always_comb begin
    op = WR_NONE;
    if (bus_valid && bus_write) begin
      case (bus_addr)
        AW'(OFF_WIPE):     op = WR_WIPE;
        AW'(OFF_MASK_OFF): op = WR_MASK_OFF;
        AW'(OFF_MASK_ON):  op = WR_MASK_ON;
        default:           op = WR_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import lvl_irq_hub_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_op_e            op,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] en_d,
  output logic [NLINES-1:0] en_q
);
  always_comb begin
    en_d = en_q;
    case (op)
      WR_WIPE:     en_d = '0;
      WR_MASK_OFF: en_d = en_q & ~wdata;
      WR_MASK_ON:  en_d = en_q | wdata;
      default:     en_d = en_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
  parameter int NLINES = 32,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NLINES-1:0]       lines,
  input  logic                    wipe,
  output logic [NLINES-1:0]       pend_d,
  output logic [NLINES-1:0]       pend_q,
  output logic [NLINES*CNT_W-1:0] cnt_flat
);
  assign pend_d = wipe ? '0 : lines;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        prev_q <= lines[g];
        if (lines[g] && !prev_q) cnt_q <= cnt_q + 1'b1;
      end
    end
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import lvl_irq_hub_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int AW     = 6,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [AW-1:0]     addr,
  input  logic [NLINES-1:0] active,
  output logic [DW-1:0]     rdata
);
  localparam int CW = $clog2(NLINES + 1);

  logic [CW-1:0] pop;
  logic [DW-1:0] rd_d;

  always_comb begin
    pop = '0;
    for (int i = 0; i < NLINES; i++) pop = pop + CW'(active[i]);
  end

  always_comb begin
    rd_d = '0;
    if (rd_req) begin
      case (addr)
        AW'(OFF_ACTIVE_CNT): rd_d = DW'(pop);
        AW'(OFF_ACTIVE_VEC): rd_d = DW'(active);
        default:             rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end
endmodule

// File: rtl/lvl_irq_hub.sv
module lvl_irq_hub
  import lvl_irq_hub_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int AW     = 6,
  parameter int DW     = 32,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NLINES-1:0]       irq_lines,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  output logic                    irq_out,
  output logic [NLINES*CNT_W-1:0] dbg_counts
);
  wr_op_e            op;
  logic [NLINES-1:0] wdata_lines;
  logic [NLINES-1:0] en_d, en_q;
  logic [NLINES-1:0] pend_d, pend_q;
  logic              wipe;

  assign wdata_lines = bus_wdata[NLINES-1:0];
  assign wipe        = (op == WR_WIPE);

  irq_wr_decode #(.AW(AW)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .op        (op)
  );

  irq_mask_reg #(.NLINES(NLINES)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .wdata (wdata_lines),
    .en_d  (en_d),
    .en_q  (en_q)
  );

  irq_line_bank #(.NLINES(NLINES), .CNT_W(CNT_W)) u_lines (
    .clk      (clk),
    .rst      (rst),
    .lines    (irq_lines),
    .wipe     (wipe),
    .pend_d   (pend_d),
    .pend_q   (pend_q),
    .cnt_flat (dbg_counts)
  );

  irq_read_port #(.NLINES(NLINES), .AW(AW), .DW(DW)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_req (bus_valid && !bus_write),
    .addr   (bus_addr),
    .active (pend_q & en_q),
    .rdata  (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(pend_d & en_d);
  end
endmodule

// File: rtl/lvl_irq_hub_chk.sv
module lvl_irq_hub_chk #(
  parameter int NLINES = 32,
  parameter int AW     = 6,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] irq_lines,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [AW-1:0]     bus_addr,
  input logic [NLINES-1:0] wdata_lines,
  input logic [DW-1:0]     bus_rdata,
  input logic              irq_out,
  input logic [NLINES-1:0] pend_q,
  input logic [NLINES-1:0] en_q
);
  logic wr_wipe, wr_off, wr_on, rd_cnt, rd_any;
  assign wr_wipe = bus_valid && bus_write && (bus_addr == AW'('h08));
  assign wr_off  = bus_valid && bus_write && (bus_addr == AW'('h0C));
  assign wr_on   = bus_valid && bus_write && (bus_addr == AW'('h10));
  assign rd_cnt  = bus_valid && !bus_write && (bus_addr == AW'('h00));
  assign rd_any  = bus_valid && !bus_write;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pend_q == '0 && en_q == '0 && !irq_out && bus_rdata == '0));

  assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
    rd_cnt |=> (bus_rdata <= DW'(NLINES)));

  assert_wipe_clears_R4: assert property (@(posedge clk) disable iff (rst)
    wr_wipe |=> (pend_q == '0 && en_q == '0));

  assert_mask_off_R5: assert property (@(posedge clk) disable iff (rst)
    wr_off |=> ((en_q & $past(wdata_lines)) == '0));

  assert_mask_on_R5: assert property (@(posedge clk) disable iff (rst)
    wr_on |=> ((en_q & $past(wdata_lines)) == $past(wdata_lines)));

  assert_level_follow_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_wipe |=> (pend_q == $past(irq_lines)));

  assert_irq_match_R7: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|(pend_q & en_q)));

  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> (bus_rdata == '0));
endmodule

bind lvl_irq_hub lvl_irq_hub_chk #(.NLINES(NLINES), .AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_lines   (irq_lines),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .wdata_lines (wdata_lines),
  .bus_rdata   (bus_rdata),
  .irq_out     (irq_out),
  .pend_q      (pend_q),
  .en_q        (en_q)
);

// File: tb/lvl_irq_hub_tb.sv
`timescale 1ns/1ps
module lvl_irq_hub_tb;
  localparam int NLINES = 32;
  localparam int AW     = 6;
  localparam int DW     = 32;
  localparam int CW     = 4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NLINES-1:0]    irq_lines = '0;
  logic                 bus_valid = 1'b0;
  logic                 bus_write = 1'b0;
  logic [AW-1:0]        bus_addr = '0;
  logic [DW-1:0]        bus_wdata = '0;
  logic [DW-1:0]        bus_rdata;
  logic                 irq_out;
  logic [NLINES*CW-1:0] dbg_counts;

  always #2 clk = ~clk;

  lvl_irq_hub #(.NLINES(NLINES), .AW(AW), .DW(DW), .CNT_W(CW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .irq_lines  (irq_lines),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_out    (irq_out),
    .dbg_counts (dbg_counts)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  bit done   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_pend = 0, m_en = 0, m_rd = 0, m_prev = 0;
  bit          m_irq = 0;
  int          m_cnt [NLINES];
  string       m_rd_tag = "R1", m_irq_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_pend = 0; m_en = 0; m_rd = 0; m_prev = 0; m_irq = 0;
      for (int i = 0; i < NLINES; i++) m_cnt[i] = 0;
      m_rd_tag = "R1"; m_irq_tag = "R1";
    end else begin
      m_rd = 0; m_rd_tag = "R9";
      if (bus_valid && !bus_write) begin
        if (bus_addr == 6'h00) begin m_rd = $countones(m_pend & m_en); m_rd_tag = "R2"; end
        else if (bus_addr == 6'h04) begin m_rd = m_pend & m_en; m_rd_tag = "R3"; end
      end
      for (int i = 0; i < NLINES; i++)
        if (irq_lines[i] && !m_prev[i]) m_cnt[i] = (m_cnt[i] + 1) % (1 << CW);
      m_irq_tag = (irq_lines != m_prev) ? "R6 R7" : "R7";
      m_prev = irq_lines;
      m_pend = irq_lines;
      if (bus_valid && bus_write) begin
        if (bus_addr == 6'h08) begin m_en = 0; m_pend = 0; m_irq_tag = "R4 R8"; end
        else if (bus_addr == 6'h0C) begin m_en = m_en & ~bus_wdata; m_irq_tag = "R5"; end
        else if (bus_addr == 6'h10) begin m_en = m_en | bus_wdata; m_irq_tag = "R5"; end
        else m_irq_tag = "R9 R7";
      end
      m_irq = (m_pend & m_en) != 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({"irq ", m_irq_tag}, {31'd0, irq_out}, {31'd0, m_irq});
      chk({"rdata ", m_rd_tag}, bus_rdata, m_rd);
      for (int i = 0; i < NLINES; i++)
        chk("count R10", 32'(dbg_counts[i*CW +: CW]), 32'(m_cnt[i]));
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    // R1: state after reset
    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    rd(6'h04, v); chk("R1 vector after reset", v, 32'd0);

    // R2 R3: masked count and vector
    wr(6'h10, 32'h0000_00FF);
    irq_lines = 32'h0000_0F0F;
    @(negedge clk);
    rd(6'h00, v); chk("R2 count", v, 32'd4);
    rd(6'h04, v); chk("R3 masked vector", v, 32'h0000_000F);
    chk("R7 irq high", {31'd0, irq_out}, 32'd1);

    // R5: clear two mask bits
    wr(6'h0C, 32'h0000_0003);
    rd(6'h04, v); chk("R5 after mask off", v, 32'h0000_000C);

    // R9: writes to read-only and unmapped offsets
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h11, 32'hFFFF_FFFF);
    rd(6'h04, v); chk("R9 writes ignored", v, 32'h0000_000C);
    rd(6'h08, v); chk("R9 read wipe offset", v, 32'd0);
    rd(6'h0C, v); chk("R9 read mask-off offset", v, 32'd0);
    rd(6'h10, v); chk("R9 read mask-on offset", v, 32'd0);
    rd(6'h24, v); chk("R9 read unmapped", v, 32'd0);

    // R4 R8: wipe with zero data while lines are high
    wr(6'h08, 32'h0);
    chk("R4 irq after wipe", {31'd0, irq_out}, 32'd0);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h04, v); chk("R8 pending returns", v, 32'h0000_0F0F);

    // R2 upper bound
    irq_lines = '1;
    @(negedge clk);
    rd(6'h00, v); chk("R2 count of all lines", v, 32'd32);

    // R10: wrap line 0 counter
    for (int k = 0; k < 20; k++) begin
      irq_lines[0] = 0; @(negedge clk);
      irq_lines[0] = 1; @(negedge clk);
    end
    irq_lines = '0;
    @(negedge clk);
    rd(6'h04, v); chk("R6 pending falls", v, 32'd0);

    // Mixed random traffic
    for (int c = 0; c < 2000; c++) begin
      int sel;
      sel = $urandom_range(0, 15);
      if ($urandom_range(0, 3) == 0) irq_lines = $urandom();
      bus_valid = 0; bus_write = 0;
      if (sel < 5) begin
        bus_valid = 1; bus_write = 0;
        bus_addr = (sel < 2) ? 6'h00 : (sel < 4) ? 6'h04 : 6'($urandom_range(0, 63));
      end else if (sel < 11) begin
        bus_valid = 1; bus_write = 1; bus_wdata = $urandom();
        case (sel)
          5, 6:    bus_addr = 6'h10;
          7, 8:    bus_addr = 6'h0C;
          9:       bus_addr = 6'($urandom_range(0, 63));
          default: bus_addr = ($urandom_range(0, 3) == 0) ? 6'h08 : 6'h04;
        endcase
      end
      @(negedge clk);
    end
    bus_valid = 0; bus_write = 0;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule